// File: doc/BRIEF.md
# Range-Gated Segmented Adder/Subtractor

This block is a pipelined 32-bit two's-complement adder and subtractor. It sizes its carry chain to the data it is given. For each accepted operation it measures how many low-order bits each addend really needs once redundant copies of the sign bit are stripped. The wider of the two measurements, plus one guard bit, sets how many 8-bit ripple-carry segments take part. In subtraction the second addend is the inverted B.

Segments outside that count do not load new operand bits. Their registers keep whatever they held, so their inputs do not toggle. The narrow sum is then sign-extended to the full word. The result is therefore always the same as a plain 32-bit wraparound add or subtract. A 4-bit status output reports which segments produced each result.

Top module: `drga_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `out_valid`, `result` and `seg_en` to zero in that cycle.
- R2: `out_valid` is high in the cycle two rising edges after a cycle with `in_valid` high. It is low two edges after a cycle with `in_valid` low. Consecutive valid cycles produce results in the same order.
- R3: The effective range of a word is the smallest n (1..32) such that sign-extending its low n bits gives back the word. The active segment count is min(4, floor((r + 8) / 8)), where r is the larger range of the two addends. `seg_en` bit i stands for result bits 8i+7..8i. For a valid result, `seg_en` shows that count as a thermometer code starting at bit 0.
- R4: When `in_sub` = 1, `result` = `in_a` - `in_b` modulo 2^32. The range of the second addend is measured on the bitwise inverse of `in_b`, and the carry into bit 0 is 1.
- R5: When `in_sub` = 0, `result` = `in_a` + `in_b` modulo 2^32, for every operand pair.
- R6: The operand register bits of a segment that is not enabled for an operation keep their previous contents. Stale contents left by an earlier wide operation never alter a later narrow result.
- R7: In a valid result, every bit above bit 8k-1 equals bit 8k-1, where k is the number of set bits in `seg_en`.
- R8: When all four segments are active, the result wraps exactly like a 32-bit add or subtract, including signed overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands in this cycle |
| in_a | input | 32 | First operand, two's complement |
| in_b | input | 32 | Second operand, two's complement |
| in_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| out_valid | output | 1 | `result` and `seg_en` hold a new value |
| result | output | 32 | Sign-extended sum or difference |
| seg_en | output | 4 | Segments used for this result (bit i = bits 8i+7..8i) |

## Verification
Several properties are checked on every cycle. The two-cycle latency holds, and every result equals the wraparound sum or difference of the operands seen two edges earlier. The segment mask is a thermometer code, the result fits the width that mask claims, and each idle segment keeps its operand registers frozen. Some behaviours need the bench's scenarios to show them. One is the exact segment count for ranges at the 7/8-bit boundaries. Another is that a narrow operation issued straight after a wide one is not disturbed by the frozen upper bits. A third is that overflow cases at full width wrap correctly.

// File: rtl/drga_pkg.sv
package drga_pkg;

    localparam int WORD_W  = 32;
    localparam int SEG_W   = 8;
    localparam int NUM_SEG = WORD_W / SEG_W;
    localparam int RANGE_W = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [NUM_SEG-1:0] seg_mask_t;
    typedef logic [RANGE_W-1:0] range_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Stage-one bookkeeping that travels with the frozen operand registers.
    typedef struct packed {
        logic      valid;
        logic      cin;
        seg_mask_t mask;
    } stage1_t;

    typedef struct packed {
        logic      valid;
        seg_mask_t mask;
        word_t     value;
    } stage2_t;

    // Significant bits of a two's-complement word: one more than the
    // highest position where a bit differs from the bit below it.
    function automatic range_t eff_range(word_t x);
        range_t n;
        n = range_t'(1);
        for (int i = 1; i < WORD_W; i++) begin
            if (x[i] ^ x[i-1]) n = range_t'(i + 1);
        end
        return n;
    endfunction

    // Thermometer mask covering range + one guard bit, capped at NUM_SEG.
    function automatic seg_mask_t seg_mask(range_t r);
        seg_mask_t m;
        int cnt;
        cnt = (int'(r) + SEG_W) / SEG_W;
        if (cnt > NUM_SEG) cnt = NUM_SEG;
        for (int i = 0; i < NUM_SEG; i++) m[i] = (i < cnt);
        return m;
    endfunction

    // True when x is the sign extension of its low n bits.
    function automatic logic fits_signed(word_t x, int n);
        logic ok;
        ok = 1'b1;
        if (n > 0 && n < WORD_W) begin
            for (int i = 0; i < WORD_W; i++) begin
                if (i >= n && x[i] != x[n-1]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/drga_width_sel.sv
module drga_width_sel
    import drga_pkg::*;
(
    input  word_t     opa,
    input  word_t     opb,
    output seg_mask_t mask
);
    range_t ra;
    range_t rb;
    range_t rmax;

    always_comb begin
        ra   = eff_range(opa);
        rb   = eff_range(opb);
        rmax = (ra > rb) ? ra : rb;
        mask = seg_mask(rmax);
    end

endmodule

// File: rtl/drga_seg.sv
module drga_seg #(
    parameter int SW = drga_pkg::SEG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          en,
    input  logic [SW-1:0] a_in,
    input  logic [SW-1:0] b_in,
    input  logic          carry_in,
    output logic [SW-1:0] sum,
    output logic          carry_out
);
    logic [SW-1:0] a_q;
    logic [SW-1:0] b_q;
    logic [SW:0]   cy;

    // Operand bits only move when this segment takes part in the operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load && en) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    assign cy[0] = carry_in;

    for (genvar i = 0; i < SW; i++) begin : g_bit
        assign sum[i]  = a_q[i] ^ b_q[i] ^ cy[i];
        assign cy[i+1] = (a_q[i] & b_q[i]) | (cy[i] & (a_q[i] ^ b_q[i]));
    end

    assign carry_out = cy[SW];

    // R6
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && en) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/drga_sign_ext.sv
module drga_sign_ext
    import drga_pkg::*;
(
    input  word_t     raw,
    input  seg_mask_t mask,
    output word_t     ext
);
    logic sign;

    // Sign bit is the top bit of the highest enabled segment.
    always_comb begin
        sign = raw[SEG_W-1];
        for (int s = 0; s < NUM_SEG; s++) begin
            if (mask[s]) sign = raw[s*SEG_W + SEG_W - 1];
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign ext[s*SEG_W +: SEG_W] = mask[s] ? raw[s*SEG_W +: SEG_W]
                                               : {SEG_W{sign}};
    end

endmodule

// File: rtl/drga_adder.sv
module drga_adder
    import drga_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_a,
    input  logic [WORD_W-1:0]   in_b,
    input  logic                in_sub,
    output logic                out_valid,
    output logic [WORD_W-1:0]   result,
    output logic [NUM_SEG-1:0]  seg_en
);
    localparam seg_mask_t ONE_MASK = seg_mask_t'(1);

    op_e       op;
    word_t     b_eff;
    seg_mask_t new_mask;
    stage1_t   s1;
    stage2_t   s2;
    word_t     raw_sum;
    word_t     ext_sum;
    logic [NUM_SEG-1:0] seg_cin;
    logic [NUM_SEG-1:0] seg_cout;

    assign op    = op_e'(in_sub);
    assign b_eff = (op == OP_SUB) ? ~in_b : in_b;

    drga_width_sel u_wsel (
        .opa  (in_a),
        .opb  (b_eff),
        .mask (new_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.cin  <= (op == OP_SUB);
                s1.mask <= new_mask;
            end
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        if (s == 0) begin : g_first
            assign seg_cin[s] = s1.cin & s1.mask[s];
        end else begin : g_rest
            assign seg_cin[s] = seg_cout[s-1] & s1.mask[s];
        end

        drga_seg #(.SW(SEG_W)) u_seg (
            .clk       (clk),
            .rst       (rst),
            .load      (in_valid),
            .en        (new_mask[s]),
            .a_in      (in_a[s*SEG_W +: SEG_W]),
            .b_in      (b_eff[s*SEG_W +: SEG_W]),
            .carry_in  (seg_cin[s]),
            .sum       (raw_sum[s*SEG_W +: SEG_W]),
            .carry_out (seg_cout[s])
        );
    end

    drga_sign_ext u_sext (
        .raw  (raw_sum),
        .mask (s1.mask),
        .ext  (ext_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            if (s1.valid) begin
                s2.value <= ext_sum;
                s2.mask  <= s1.mask;
            end
        end
    end

    assign out_valid = s2.valid;
    assign result    = s2.value;
    assign seg_en    = s2.mask;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R2
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R5
    exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (result == $past(in_sub ? (in_a - in_b) : (in_a + in_b), 2)));

    // R3
    seg_therm_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seg_en[0] && ((seg_en & (seg_en + ONE_MASK)) == '0)));

    // R7
    sext_fit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> fits_signed(result, $countones(seg_en) * SEG_W));

endmodule

// File: tb/drga_adder_test.sv
module drga_adder_test;
    import drga_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sub = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  seg_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit          p1_v = 1'b0, p2_v = 1'b0;
    bit          p1_s = 1'b0, p2_s = 1'b0;
    logic [31:0] p1_a = '0, p2_a = '0, p1_b = '0, p2_b = '0;
    string       p1_r = "R2", p2_r = "R2";

    always #5 clk = ~clk;

    drga_adder uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_sub    (in_sub),
        .out_valid (out_valid),
        .result    (result),
        .seg_en    (seg_en)
    );

    // Smallest n whose sign extension reproduces x.
    function automatic int tb_range(logic [31:0] x);
        for (int n = 1; n < 32; n++) begin
            logic [31:0] t;
            t = 32'($signed(x << (32 - n)) >>> (32 - n));
            if (t == x) return n;
        end
        return 32;
    endfunction

    function automatic logic [31:0] tb_result(logic [31:0] a, logic [31:0] b, bit s);
        return s ? a - b : a + b;
    endfunction

    function automatic logic [3:0] tb_mask(logic [31:0] a, logic [31:0] b, bit s);
        int r;
        int k;
        logic [3:0] m;
        r = tb_range(a);
        if (tb_range(s ? ~b : b) > r) r = tb_range(s ? ~b : b);
        k = (r + 8) / 8;
        if (k > 4) k = 4;
        m = '0;
        for (int i = 0; i < k; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic bit tb_sext_ok(logic [31:0] x, logic [3:0] m);
        int n;
        n = 8 * $countones(m);
        if (n == 0 || n == 32) return 1'b1;
        for (int j = n; j < 32; j++) if (x[j] != x[n-1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] rnd_op();
        int k;
        logic [31:0] v;
        k = $urandom_range(1, 32);
        v = $urandom;
        if (k < 32) v = 32'($signed(v << (32 - k)) >>> (32 - k));
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: check the operation issued two cycles ago, then drive a new one.
    task automatic step(bit v, logic [31:0] a, logic [31:0] b, bit s, string req);
        @(negedge clk);
        check("R2", {31'b0, out_valid}, {31'b0, p2_v});
        if (p2_v && out_valid) begin
            check(p2_r, result, tb_result(p2_a, p2_b, p2_s));
            check("R3", {28'b0, seg_en}, {28'b0, tb_mask(p2_a, p2_b, p2_s)});
            check("R7", {31'b0, tb_sext_ok(result, seg_en)}, 32'd1);
        end
        p2_v = p1_v; p2_a = p1_a; p2_b = p1_b; p2_s = p1_s; p2_r = p1_r;
        p1_v = v;    p1_a = a;    p1_b = b;    p1_s = s;    p1_r = req;
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_sub   = s;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        void'($urandom(32'd90210));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {31'b0, out_valid}, 32'd0);
        check("R1", result, 32'd0);
        check("R1", {28'b0, seg_en}, 32'd0);
        rst = 1'b0;

        // R3 segment-count boundaries
        step(1, 32'd0, 32'd0, 0, "R3");
        step(1, 32'd63, 32'd1, 0, "R3");
        step(1, 32'd127, 32'd0, 0, "R3");
        step(1, 32'hFFFF_FF80, 32'd5, 0, "R3");
        step(1, 32'h0000_7FFF, 32'd1, 0, "R3");
        step(1, 32'h0080_0000, 32'd2, 0, "R3");
        // R4 subtraction, range taken on inverted B
        step(1, 32'd10, 32'd0, 1, "R4");
        step(1, 32'd10, 32'd128, 1, "R4");
        step(1, 32'hFFFF_FFFE, 32'd3, 1, "R4");
        // R8 full-width overflow wrap
        step(1, 32'h7FFF_FFFF, 32'd1, 0, "R8");
        step(1, 32'h8000_0000, 32'd1, 1, "R8");
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R8");
        step(1, 32'h8000_0000, 32'h7FFF_FFFF, 1, "R8");
        // R6 narrow operations right after a wide one
        step(1, 32'h1234_5678, 32'h0F0F_0F0F, 0, "R6");
        step(1, 32'd5, 32'd3, 0, "R6");
        step(1, 32'hFFFF_FFFE, 32'd3, 1, "R6");
        step(0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0, "R2");
        step(1, 32'd100, 32'hFFFF_FF9C, 0, "R6");
        // R2 gaps and bubbles
        step(0, 32'd0, 32'd0, 0, "R2");
        step(0, 32'd0, 32'd0, 0, "R2");
        step(1, 32'd1, 32'd1, 0, "R5");

        // R5 / R4 random mix with valid gaps
        for (int i = 0; i < 2000; i++) begin
            bit v;
            bit s;
            v = ($urandom_range(0, 9) < 8);
            s = $urandom_range(0, 1);
            step(v, rnd_op(), rnd_op(), s, s ? "R4" : "R5");
        end

        repeat (3) step(0, 32'd0, 32'd0, 0, "R2");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule